// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the access address for a four-beat burst into a synchronous memory. When a load strobe arrives, the block captures the whole external address. The two lowest bits of that address give the starting beat offset, and the block remembers the order-select input. On each later advance strobe it moves to the next address of the burst. The upper address bits stay fixed for the whole burst.

Two orders are supported. The linear order counts upward from the start offset and wraps modulo four. The interleaved order XORs the start offset with a running beat count. A clock-enable style hold input freezes the block completely. The order-select input is read only when an address is loaded, so it behaves as a static strap for the duration of a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the address output becomes zero on that edge.
- R2: A cycle with `hold_i` low and `load_i` high makes `addr_o` equal to `addr_i` from the next cycle on, and the beat count restarts at zero.
- R3: If `ilv_i` was 0 at the load, each advance (`adv_i` high, `hold_i` and `load_i` low) sets the two low bits to the previous value plus one, modulo 4. Starting at 1, the sequence is 1,2,3,0.
- R4: If `ilv_i` was 1 at the load, the two low bits after k advances equal the start offset XOR (k mod 4). Starting at 1, the sequence is 1,0,3,2. Starting at 2, it is 2,3,0,1.
- R5: After the fourth advance the low bits return to the start offset, and the sequence then repeats.
- R6: Bits above bit 1 of `addr_o` keep the value loaded from `addr_i` across every advance.
- R7: With `hold_i` high, `addr_o` does not change, whatever `load_i`, `adv_i`, `ilv_i` and `addr_i` are.
- R8: A change of `ilv_i` after the load has no effect on the order until the next load.
- R9: When `load_i` and `adv_i` are both high (and `hold_i` is low), the load wins.
- R10: With `hold_i` low and both strobes low, `addr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_i | input | 1 | High freezes all state |
| load_i | input | 1 | Capture `addr_i` and start a burst |
| adv_i | input | 1 | Step to the next burst address |
| ilv_i | input | 1 | Order select, read at load: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current access address |

## Verification
The hardest case to reach is an order-select change in the middle of a burst. From the ports alone it cannot be told apart from a fresh start unless the sequence is followed past the change. The stimulus therefore loads in one mode and flips `ilv_i` while advancing. It then compares more than four beats against the order latched at the load, for both directions of the flip. A full sweep of every start offset in both orders, running past the wrap, covers the offsets where the two orders first differ.

// File: rtl/burst_addr_seq_pkg.sv
// Shared types for the burst address sequencer.
package burst_addr_seq_pkg;

    // Burst order captured at load time.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Action taken by the state registers on a clock edge.
    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } seq_action_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
// Decodes hold, load and advance strobes into one action.
// Priority: hold over load over advance. Assumes strobes are synchronous.
module burst_seq_ctrl
    import burst_addr_seq_pkg::*;
(
    input  logic        hold_i,
    input  logic        load_i,
    input  logic        adv_i,
    output seq_action_e act_o
);

    // Priority decode of the incoming strobes.
    always_comb begin
        if (hold_i)      act_o = ACT_KEEP;
        else if (load_i) act_o = ACT_LOAD;
        else if (adv_i)  act_o = ACT_STEP;
        else             act_o = ACT_KEEP;
    end

endmodule

// File: rtl/burst_seq_state.sv
// Holds the burst context: upper address, start offset, beat count and order.
// Assumes the action input is already prioritised; count wraps naturally.
module burst_seq_state
    import burst_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seq_action_e              act_i,
    input  logic                     ilv_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [ADDR_W-BEAT_W-1:0] upper_o,
    output logic [BEAT_W-1:0]        start_o,
    output logic [BEAT_W-1:0]        count_o,
    output burst_order_e             order_o
);

    localparam int UP_W = ADDR_W - BEAT_W;

    // Context registers: captured on load, count advanced on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_o <= '0;
            start_o <= '0;
            count_o <= '0;
            order_o <= ORD_LINEAR;
        end else begin
            case (act_i)
                ACT_LOAD: begin
                    upper_o <= addr_i[ADDR_W-1:BEAT_W];
                    start_o <= addr_i[BEAT_W-1:0];
                    count_o <= '0;
                    order_o <= burst_order_e'(ilv_i);
                end
                ACT_STEP: count_o <= count_o + 1'b1;
                default:  ;
            endcase
        end
    end

    logic unused_up;
    assign unused_up = (UP_W < 0);

endmodule

// File: rtl/burst_seq_map.sv
// Maps start offset and beat count onto the low address bits.
// Linear: modular sum. Interleaved: bitwise XOR. Purely combinational.
module burst_seq_map
    import burst_addr_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] count_i,
    input  burst_order_e      order_i,
    output logic [BEAT_W-1:0] low_o
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Per-bit interleave term, one XOR per offset bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_i[b] ^ count_i[b];
    end

    // Linear offset wraps within the beat field width.
    assign lin_low = start_i + count_i;

    // Select the order captured at load.
    always_comb begin
        low_o = (order_i == ORD_INTERLEAVE) ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Top of the burst address sequencer. Loads an address, then steps the
// low BEAT_W bits in linear or interleaved order on each advance.
// Assumes ilv_i is static during a burst; it is read only at load.
module burst_addr_seq
    import burst_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              ilv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UP_W = ADDR_W - BEAT_W;

    seq_action_e       act;
    logic [UP_W-1:0]   upper;
    logic [BEAT_W-1:0] start;
    logic [BEAT_W-1:0] count;
    logic [BEAT_W-1:0] low;
    burst_order_e      order;

    burst_seq_ctrl u_ctrl (
        .hold_i (hold_i),
        .load_i (load_i),
        .adv_i  (adv_i),
        .act_o  (act)
    );

    burst_seq_state #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act),
        .ilv_i   (ilv_i),
        .addr_i  (addr_i),
        .upper_o (upper),
        .start_o (start),
        .count_o (count),
        .order_o (order)
    );

    burst_seq_map #(
        .BEAT_W (BEAT_W)
    ) u_map (
        .start_i (start),
        .count_i (count),
        .order_i (order),
        .low_o   (low)
    );

    // Assemble the access address from fixed upper bits and mapped offset.
    assign addr_o = {upper, low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Property checker for burst_addr_seq, bound to every instance.
// Tracks the order latched at load to judge each advance.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_i,
    input logic              load_i,
    input logic              adv_i,
    input logic              ilv_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o
);

    logic shadow_ilv;
    logic step;

    assign step = !hold_i && !load_i && adv_i;

    // Shadow of the order select as seen at the last load.
    always_ff @(posedge clk) begin
        if (!rst_n)                shadow_ilv <= 1'b0;
        else if (!hold_i && load_i) shadow_ilv <= ilv_i;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> addr_o == '0);

    // R2, R9
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && load_i) |=> addr_o == $past(addr_i));

    // R3, R8
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !shadow_ilv) |=>
        addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1));

    // R4
    ilv_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && shadow_ilv) |=> addr_o[0] != $past(addr_o[0]));

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(addr_o));

    // R10
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !load_i && !adv_i) |=> $stable(addr_o));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (hold_i),
    .load_i (load_i),
    .adv_i  (adv_i),
    .ilv_i  (ilv_i),
    .addr_i (addr_i),
    .addr_o (addr_o)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every start offset in both orders past the wrap,
// plus hold, idle, strobe priority and mid-burst order changes.
module burst_addr_seq_test;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold_i = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          ilv_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int total = 0;
    int bad = 0;

    // Bench-side reference of the burst context.
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_ilv = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold_i),
        .load_i (load_i),
        .adv_i  (adv_i),
        .ilv_i  (ilv_i),
        .addr_i (addr_i),
        .addr_o (addr_o)
    );

    function automatic logic [AW-1:0] expect_addr();
        logic [1:0] low;
        low = m_ilv ? (m_start ^ m_cnt) : 2'(m_start + m_cnt);
        return {m_up, low};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] exp);
        total++;
        if (addr_o !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, addr_o, exp);
        end
    endtask

    // One clock: drive, let the edge pass, update the model, compare.
    task automatic cyc(input string tag, input logic h, input logic l,
                       input logic a, input logic m, input logic [AW-1:0] ad);
        hold_i = h; load_i = l; adv_i = a; ilv_i = m; addr_i = ad;
        @(posedge clk);
        #1;
        if (!h) begin
            if (l) begin
                m_up = ad[AW-1:2]; m_start = ad[1:0]; m_cnt = '0; m_ilv = m;
            end else if (a) begin
                m_cnt = m_cnt + 2'd1;
            end
        end
        check(tag, expect_addr());
    endtask

    initial begin
        #(5.0 * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        hold_i = 1'b0; load_i = 1'b1; adv_i = 1'b1; addr_i = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", '0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: every start offset, both orders, eight advances
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] a0;
                a0 = {6'(8'h15 + 8'(s * 13 + md * 29)), 2'(s)};
                cyc("R2 load", 1'b0, 1'b1, 1'b0, md[0], a0);
                for (int k = 0; k < 8; k++)
                    cyc(md ? "R4 R5 R6 interleaved" : "R3 R5 R6 linear",
                        1'b0, 1'b0, 1'b1, md[0], 8'h00);
            end
        end

        // R4: literal sequences from the requirement text
        cyc("R2 load", 1'b0, 1'b1, 1'b0, 1'b1, 8'hA2);
        cyc("R4 2->3", 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R4 literal 3", 8'hA3);

        // R7: hold freezes despite strobes
        cyc("R2 load", 1'b0, 1'b1, 1'b0, 1'b0, 8'h41);
        cyc("R3 step", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        check("R3 literal 2", 8'h42);
        for (int k = 0; k < 4; k++)
            cyc("R7 hold", 1'b1, k[0], 1'b1, k[1], 8'(8'hC0 + k));
        cyc("R3 after hold", 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R3 literal 3", 8'h43);

        // R10: idle keeps address
        repeat (3) cyc("R10 idle", 1'b0, 1'b0, 1'b0, 1'b1, 8'h77);

        // R9: load beats advance
        cyc("R9 both strobes", 1'b0, 1'b1, 1'b1, 1'b0, 8'h5E);
        check("R9 literal", 8'h5E);

        // R8: order change mid-burst, both directions
        for (int md = 0; md < 2; md++) begin
            cyc("R2 load", 1'b0, 1'b1, 1'b0, md[0], 8'h91);
            for (int k = 0; k < 6; k++)
                cyc("R8 mode flip", 1'b0, 1'b0, 1'b1, ~md[0], 8'h00);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule